// File: doc/BRIEF.md
# Snoop Tag Port Arbiter

This block owns the tag array of an inclusive second-level cache that has only one port. Two clients share that port: the processor, which looks up lines or installs them, and the coherence bus, which sends snoop lookups. Each cycle serves at most one lookup. A snoop that is accepted always takes the port. While it does, the block raises a stall to the processor, and the processor holds its request until a cycle with no snoop in it.

A snoop may carry an invalidate flag. If such a snoop hits, the block clears the stored line state and forwards an invalidate for the same line to the first-level tag array. That invalidate waits in a single holding register until the first-level cache accepts it. While the register is full and the first-level cache is not ready, the snoop channel is back-pressured. All address compares work on 64-byte lines, so the six offset bits are never examined.

Line state is a 2-bit code. Code 0 means invalid and codes 1 to 3 mean valid. The block does not interpret the valid codes: it only stores them and returns them.

Top module: `snoop_tag_arbiter`

## Requirements
- R1: In a cycle where a snoop is accepted (snp_req_valid and snp_ready both high), cpu_stall is high, the processor request is not performed, and no processor response follows in the next cycle.
- R2: One cycle after a snoop is accepted, snp_resp_valid is high. snp_resp_hit is 1 when the stored state of the addressed line is non-zero and its tag matches. snp_resp_state is the stored 2-bit state on a hit and 0 otherwise.
- R3: A processor request is performed in any cycle with cpu_req_valid high and no accepted snoop. A requester that holds a stalled request is served in the first such cycle. A lookup (cpu_req_write=0) responds one cycle later with hit and state under the rules of R2. A write (cpu_req_write=1) stores the request's tag and cpu_req_state for its line and gives no response.
- R4: Address compares for both clients use address bits [AW-1:6] only. Two addresses that differ only in bits [5:0] select the same line.
- R5: A snoop with snp_req_inv=1 that hits sets the line state to 0. In the next cycle it raises l1_inv_valid with l1_inv_line equal to the snoop address bits [AW-1:6].
- R6: l1_inv_valid and l1_inv_line hold until a cycle with l1_inv_ready high. snp_ready is low exactly when l1_inv_valid is high and l1_inv_ready is low. A new invalidate may load in the same cycle the old one drains.
- R7: A snoop that misses, or that has snp_req_inv=0, raises no first-level invalidate and leaves the stored state of every line unchanged.
- R8: After reset all lines are invalid, every response and invalidate output is low, and snp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = install tag and state, 0 = lookup |
| cpu_req_addr | input | AW | Processor byte address |
| cpu_req_state | input | 2 | State code written on install |
| cpu_stall | output | 1 | Snoop holds the tag port this cycle |
| cpu_resp_valid | output | 1 | Lookup result valid |
| cpu_resp_hit | output | 1 | Lookup hit |
| cpu_resp_state | output | 2 | Stored state on hit, else 0 |
| snp_req_valid | input | 1 | Snoop request present |
| snp_req_inv | input | 1 | Invalidate the line on hit |
| snp_req_addr | input | AW | Snoop byte address |
| snp_ready | output | 1 | Snoop can be accepted |
| snp_resp_valid | output | 1 | Snoop result valid |
| snp_resp_hit | output | 1 | Snoop hit |
| snp_resp_state | output | 2 | State before the snoop on hit, else 0 |
| l1_inv_valid | output | 1 | First-level invalidate pending |
| l1_inv_line | output | AW-6 | Line address to invalidate |
| l1_inv_ready | input | 1 | First-level tag array accepts invalidate |

## Verification
The bench builds the block with SETS=4 and the default 32-bit address. With only four sets, a few tag values are enough to make lines alias on an index and to drive both hits and misses, including a snoop and a processor request aimed at the same set in the same cycle. Random offset bits exercise the line-granular compare. The first-level ready input is held low over many cycles, so a full holding register, back-pressure, and a drain with a same-cycle reload all occur often.

// File: rtl/snoop_tag_arbiter.sv
module snoop_tag_arbiter #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_req_valid,
  input  logic                              cpu_req_write,
  input  logic [AW-1:0]                     cpu_req_addr,
  input  logic [1:0]                        cpu_req_state,
  output logic                              cpu_stall,
  output logic                              cpu_resp_valid,
  output logic                              cpu_resp_hit,
  output logic [1:0]                        cpu_resp_state,
  input  logic                              snp_req_valid,
  input  logic                              snp_req_inv,
  input  logic [AW-1:0]                     snp_req_addr,
  output logic                              snp_ready,
  output logic                              snp_resp_valid,
  output logic                              snp_resp_hit,
  output logic [1:0]                        snp_resp_state,
  output logic                              l1_inv_valid,
  output logic [AW-$clog2(LINE_BYTES)-1:0]  l1_inv_line,
  input  logic                              l1_inv_ready
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam int IW  = $clog2(SETS);
  localparam int TW  = AW - OFS - IW;

  logic [TW-1:0] tag_q [SETS];
  logic [1:0]    st_q  [SETS];

  logic          snp_go, cpu_go, lk_hit, lookup;
  logic [AW-1:0] lk_addr;
  logic [IW-1:0] lk_idx;
  logic [TW-1:0] lk_tag;
  logic [1:0]    lk_st;

  assign snp_ready = !l1_inv_valid || l1_inv_ready;
  assign snp_go    = snp_req_valid && snp_ready;
  assign cpu_stall = snp_go;
  assign cpu_go    = cpu_req_valid && !snp_go;
  assign lookup    = cpu_go && !cpu_req_write;

  assign lk_addr = snp_go ? snp_req_addr : cpu_req_addr;
  assign lk_idx  = lk_addr[OFS +: IW];
  assign lk_tag  = lk_addr[AW-1 -: TW];
  assign lk_st   = st_q[lk_idx];
  assign lk_hit  = (lk_st != 2'd0) && (tag_q[lk_idx] == lk_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= 2'd0;
      end
      snp_resp_valid <= 1'b0;
      snp_resp_hit   <= 1'b0;
      snp_resp_state <= 2'd0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      cpu_resp_state <= 2'd0;
      l1_inv_valid   <= 1'b0;
      l1_inv_line    <= '0;
    end else begin
      snp_resp_valid <= snp_go;
      snp_resp_hit   <= snp_go && lk_hit;
      snp_resp_state <= (snp_go && lk_hit) ? lk_st : 2'd0;
      cpu_resp_valid <= lookup;
      cpu_resp_hit   <= lookup && lk_hit;
      cpu_resp_state <= (lookup && lk_hit) ? lk_st : 2'd0;
      if (snp_go && snp_req_inv && lk_hit) begin
        st_q[lk_idx] <= 2'd0;
        l1_inv_valid <= 1'b1;
        l1_inv_line  <= snp_req_addr[AW-1:OFS];
      end else if (l1_inv_ready) begin
        l1_inv_valid <= 1'b0;
      end
      if (cpu_go && cpu_req_write) begin
        tag_q[lk_idx] <= lk_tag;
        st_q[lk_idx]  <= cpu_req_state;
      end
    end
  end

  AST_ONE_USER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_resp_valid && snp_resp_valid)); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> !cpu_resp_valid); // R1
  AST_SNOOP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req_valid && snp_ready) |=> snp_resp_valid); // R2
  AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_inv_valid && !l1_inv_ready) |=> (l1_inv_valid && $stable(l1_inv_line))); // R6
  AST_INV_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l1_inv_valid) |-> (snp_resp_valid && snp_resp_hit)); // R5
  AST_MISS_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_resp_valid && !snp_resp_hit) |-> !$rose(l1_inv_valid)); // R7
endmodule

// File: tb/snoop_tag_arbiter_tb.sv
`timescale 1ns/1ps
module snoop_tag_arbiter_tb;
  localparam int AW = 32;
  localparam int SETS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cv = 0, cw = 0, sv = 0, si = 0, l1r = 1;
  logic [AW-1:0] ca = 0, sa = 0;
  logic [1:0] cs = 0;
  logic cpu_stall, cpu_resp_valid, cpu_resp_hit, snp_ready, snp_resp_valid, snp_resp_hit, l1_inv_valid;
  logic [1:0] cpu_resp_state, snp_resp_state;
  logic [AW-7:0] l1_inv_line;

  snoop_tag_arbiter #(.AW(AW), .LINE_BYTES(64), .SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cv), .cpu_req_write(cw), .cpu_req_addr(ca), .cpu_req_state(cs),
    .cpu_stall(cpu_stall), .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
    .cpu_resp_state(cpu_resp_state),
    .snp_req_valid(sv), .snp_req_inv(si), .snp_req_addr(sa), .snp_ready(snp_ready),
    .snp_resp_valid(snp_resp_valid), .snp_resp_hit(snp_resp_hit), .snp_resp_state(snp_resp_state),
    .l1_inv_valid(l1_inv_valid), .l1_inv_line(l1_inv_line), .l1_inv_ready(l1_inv_ready_w));

  logic l1_inv_ready_w;
  assign l1_inv_ready_w = l1r;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference
  int m_tag [SETS];
  int m_st  [SETS];
  bit m_inv_v; int m_inv_line;
  bit m_sv, m_sh; int m_ss;
  bit m_cv, m_ch; int m_cs;

  function automatic bit m_ready();
    return !m_inv_v || l1r;
  endfunction
  function automatic bit m_sgo();
    return sv && m_ready();
  endfunction
  function automatic int set_of(input logic [AW-1:0] a);
    return int'(a[31:6]) % SETS;
  endfunction
  function automatic int tag_of(input logic [AW-1:0] a);
    return int'(a[31:6]) / SETS;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin m_tag[i] = 0; m_st[i] = 0; end
      m_inv_v = 0; m_inv_line = 0;
      m_sv = 0; m_sh = 0; m_ss = 0; m_cv = 0; m_ch = 0; m_cs = 0;
    end else begin
      bit sgo, cgo, hit, l1drain;
      sgo = m_sgo();
      cgo = cv && !sgo;
      l1drain = l1r;
      m_sv = sgo; m_sh = 0; m_ss = 0;
      m_cv = cgo && !cw; m_ch = 0; m_cs = 0;
      if (sgo) begin
        hit = m_st[set_of(sa)] != 0 && m_tag[set_of(sa)] == tag_of(sa);
        m_sh = hit; m_ss = hit ? m_st[set_of(sa)] : 0;
        if (hit && si) begin
          m_st[set_of(sa)] = 0; m_inv_v = 1; m_inv_line = int'(sa[31:6]);
        end else if (l1drain) m_inv_v = 0;
      end else begin
        if (l1drain) m_inv_v = 0;
        if (cgo) begin
          hit = m_st[set_of(ca)] != 0 && m_tag[set_of(ca)] == tag_of(ca);
          if (cw) begin m_tag[set_of(ca)] = tag_of(ca); m_st[set_of(ca)] = int'(cs); end
          else begin m_ch = hit; m_cs = hit ? m_st[set_of(ca)] : 0; end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1", "cpu_stall", int'(cpu_stall), int'(m_sgo()));
    chk("R6", "snp_ready", int'(snp_ready), int'(m_ready()));
    chk("R2", "snp_resp_valid", int'(snp_resp_valid), int'(m_sv));
    chk("R2", "snp_resp_hit", int'(snp_resp_hit), int'(m_sh));
    chk("R2", "snp_resp_state", int'(snp_resp_state), m_ss);
    chk("R3", "cpu_resp_valid", int'(cpu_resp_valid), int'(m_cv));
    chk("R3", "cpu_resp_hit", int'(cpu_resp_hit), int'(m_ch));
    chk("R3", "cpu_resp_state", int'(cpu_resp_state), m_cs);
    chk("R5", "l1_inv_valid", int'(l1_inv_valid), int'(m_inv_v));
    if (m_inv_v) chk("R5", "l1_inv_line", int'(l1_inv_line), m_inv_line);
  endtask

  task automatic cyc(input bit c_v, input bit c_w, input logic [AW-1:0] c_a, input logic [1:0] c_s,
                     input bit s_v, input bit s_i, input logic [AW-1:0] s_a, input bit r);
    @(negedge clk);
    cv = c_v; cw = c_w; ca = c_a; cs = c_s; sv = s_v; si = s_i; sa = s_a; l1r = r;
    #1 compare_all();
  endtask

  task automatic idle(input bit r);
    cyc(0, 0, 0, 0, 0, 0, 0, r);
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int s, input int o);
    return AW'((t * SETS + s) * 64 + o);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R8 reset state
    chk("R8", "reset snp_ready", int'(snp_ready), 1);
    chk("R8", "reset outputs", int'({cpu_resp_valid, snp_resp_valid, l1_inv_valid, cpu_stall}), 0);
    cyc(1, 0, mk(1, 2, 5), 0, 0, 0, 0, 1);
    idle(1);
    chk("R8", "line invalid after reset", int'(cpu_resp_hit), 0);

    // R4: install with offset 0, lookup with another offset
    cyc(1, 1, mk(1, 2, 0), 2'd3, 0, 0, 0, 1);
    cyc(1, 0, mk(1, 2, 37), 0, 0, 0, 0, 1);
    idle(1);
    chk("R4", "lookup other offset hit", int'(cpu_resp_hit), 1);
    chk("R4", "lookup state", int'(cpu_resp_state), 3);

    // R1/R3: snoop collides with cpu lookup; cpu held and served next
    cyc(1, 0, mk(1, 2, 1), 0, 1, 0, mk(1, 2, 9), 1);
    chk("R1", "stall during snoop", int'(cpu_stall), 1);
    cyc(1, 0, mk(1, 2, 1), 0, 0, 0, 0, 1);
    chk("R1", "no cpu resp after stalled cycle", int'(cpu_resp_valid), 0);
    chk("R2", "snoop hit", int'(snp_resp_hit), 1);
    idle(1);
    chk("R3", "held request served", int'(cpu_resp_valid), 1);

    // R7: invalidating snoop that misses (different tag)
    cyc(0, 0, 0, 0, 1, 1, mk(2, 2, 4), 1);
    idle(1);
    chk("R7", "miss no inv", int'(l1_inv_valid), 0);
    cyc(1, 0, mk(1, 2, 0), 0, 0, 0, 0, 1);
    idle(1);
    chk("R7", "state unchanged after miss", int'(cpu_resp_state), 3);

    // R5/R6: invalidating hit with L1 busy, back-pressure, then drain
    cyc(1, 1, mk(0, 1, 0), 2'd1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, mk(1, 2, 63), 0);
    cyc(0, 0, 0, 0, 1, 1, mk(0, 1, 2), 0);
    chk("R6", "back-pressure", int'(snp_ready), 0);
    chk("R5", "inv line", int'(l1_inv_line), (1 * SETS + 2));
    cyc(0, 0, 0, 0, 1, 1, mk(0, 1, 2), 0);
    chk("R6", "inv held", int'(l1_inv_valid), 1);
    cyc(0, 0, 0, 0, 1, 1, mk(0, 1, 2), 1);
    chk("R6", "ready on drain", int'(snp_ready), 1);
    idle(1);
    chk("R6", "reload on drain", int'(l1_inv_line), (0 * SETS + 1));
    cyc(1, 0, mk(1, 2, 0), 0, 0, 0, 0, 1);
    idle(1);
    chk("R5", "line cleared", int'(cpu_resp_hit), 0);

    // random traffic
    begin
      bit hold_c = 0;
      for (int n = 0; n < 4000; n++) begin
        bit nv, nw, s_v, s_i, r;
        logic [AW-1:0] na, s_a;
        logic [1:0] ns;
        if (hold_c) begin nv = cv; nw = cw; na = ca; ns = cs; end
        else begin
          nv = ($urandom % 3) != 0; nw = ($urandom % 3) == 0;
          na = mk($urandom % 3, $urandom % SETS, $urandom % 64); ns = 2'($urandom);
        end
        s_v = ($urandom % 3) == 0; s_i = $urandom % 2;
        s_a = mk($urandom % 3, $urandom % SETS, $urandom % 64);
        r = ($urandom % 4) == 0;
        cyc(nv, nw, na, ns, s_v, s_i, s_a, r);
        hold_c = nv && cpu_stall;
      end
    end
    idle(1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule